// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A synthesizable model of a synchronous static memory that keeps its data bus fully occupied when traffic alternates between reads and writes. Every command is captured on the rising clock edge. Read data appears two bus cycles after its address. Write data is taken two cycles after its address, so a write can directly follow a read, and a read can directly follow a write, with no idle cycle between them. Each word has four 9-bit lanes. A lane is eight data bits plus one parity bit, and each lane has its own active-low write enable.

A command either loads a new address or continues the current burst. A continue step moves to the next address in a four-beat group. The group is walked in linear or interleaved order, chosen by a static select input. A clock-hold input freezes every register in the pipeline. A sleep input stops the block after a two-edge delay and keeps the memory contents. The output enable gates the read data at any moment, with no clock needed. The data bus is modelled as a data output plus a valid flag, not as tristate pads.

Top module: `pipe_burst_sram`

## Requirements
- R1: When a read command (load_n low, chip selected, wr_n high) is taken at edge E, its word appears on rdata with rvalid high after edge E+1 and stays until the next edge. After any edge that completes no read, rvalid is low.
- R2: For a write command taken at edge E, the address and lane enables are captured at E, and the data is taken from wdata at edge E+2. Reads and writes may follow one another in consecutive cycles with no idle cycle.
- R3: Lane i is bits 9i+8..9i and is written only when lane_wen_n[i] is low. If wr_n is low and all four lane enables are high, nothing is written, but the burst still advances.
- R4: While a burst is active, a cycle with load_n high issues the next address in the same group of four. Only the two low address bits change, by step k from the start value s. With burst_lin high the order is linear, (s+k) mod 4. With burst_lin low the order is interleaved, s xor k. After four steps the sequence wraps to the start.
- R5: The chip is selected only when en1_n is low, en2 is high and en3_n is low. A load_n low cycle without that selection ends any burst. Later load_n high cycles then issue nothing until a new load.
- R6: While stall is high, all synchronous inputs are ignored and every register holds, including the read output and the pending write stages. A stalled edge does not count toward the write-data delay.
- R7: out_en_n acts with no clock. While it is high, rvalid is low and rdata is zero. A read issued with out_en_n high still advances the burst.
- R8: After sleep rises, two more edges run normally; from the third edge on, all other inputs are ignored, the state and memory are kept, and rvalid is low. After sleep falls, two more edges are ignored and the third one runs.
- R9: A read issued one cycle after a write to the same address returns the new data in the lanes that write enables. The other lanes keep their stored data.
- R10: Reset clears every pending read and write, so that no output appears and no write lands after reset. The memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| stall | input | 1 | High: freeze all registers and ignore synchronous inputs |
| en1_n | input | 1 | Chip select, active low |
| en2 | input | 1 | Chip select, active high |
| en3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: start a new command; high: continue the burst |
| wr_n | input | 1 | Low: write, high: read (sampled with load_n low) |
| lane_wen_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address, taken on load |
| wdata | input | 36 | Write data, taken two cycles after its command |
| burst_lin | input | 1 | Static burst order: high linear, low interleaved |
| out_en_n | input | 1 | Output enable, active low, no clock needed |
| sleep | input | 1 | Power-down request, active high |
| rdata | output | 36 | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
On every cycle, the assertions check that stall and sleep freeze the pipeline and burst state, and that a pending write stage or a rising valid flag always comes from a matching command one edge earlier. They also check that a deselect empties the issue stage and that each burst continue steps the counter by one. Only the bench scenarios show the data values. These include the lane merges and the abort, the forwarding of data from a write still in flight, both burst orders with their wrap, the output enable acting between edges, and the check that reset and sleep leave the stored words untouched.

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stall,
  input  logic                  en1_n,
  input  logic                  en2,
  input  logic                  en3_n,
  input  logic                  load_n,
  input  logic                  wr_n,
  input  logic [LANES-1:0]      lane_wen_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic                  burst_lin,
  input  logic                  out_en_n,
  input  logic                  sleep,
  output logic [LANES*LW-1:0]   rdata,
  output logic                  rvalid
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic slp1, slp2;
  logic act, op_wr;
  logic [AW-1:0] base;
  logic [1:0] cnt;
  logic p1_v, p1_wr, p2_v, rv_q;
  logic [AW-1:0] p1_a, p2_a;
  logic [LANES-1:0] p1_m, p2_m;
  logic [DW-1:0] rd_q, fwd;

  wire run = !stall && !slp2;
  wire sel = !en1_n && en2 && !en3_n;

  wire [1:0]    nxt_cnt  = load_n ? cnt + 2'd1 : 2'd0;
  wire [AW-1:0] start    = load_n ? base : addr;
  wire [1:0]    low      = burst_lin ? start[1:0] + nxt_cnt : start[1:0] ^ nxt_cnt;
  wire [AW-1:0] ea       = {start[AW-1:2], low};
  wire          issue    = load_n ? act : sel;
  wire          issue_wr = load_n ? op_wr : !wr_n;
  wire          hit      = p2_v && (p2_a == p1_a);

  always_comb begin
    for (int i = 0; i < LANES; i++)
      fwd[i*LW +: LW] = (hit && !p2_m[i]) ? wdata[i*LW +: LW] : mem[p1_a][i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slp1 <= 1'b0;
      slp2 <= 1'b0;
      act  <= 1'b0;
      cnt  <= 2'd0;
      p1_v <= 1'b0;
      p2_v <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      slp1 <= sleep;
      slp2 <= slp1;
      if (run) begin
        if (!load_n) act <= sel;
        cnt  <= nxt_cnt;
        p1_v <= issue;
        p2_v <= p1_v && p1_wr;
        rv_q <= p1_v && !p1_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (run) begin
      if (!load_n) begin
        op_wr <= !wr_n;
        base  <= addr;
      end
      p1_wr <= issue_wr;
      p1_a  <= ea;
      p1_m  <= lane_wen_n;
      p2_a  <= p1_a;
      p2_m  <= p1_m;
      if (p1_v && !p1_wr) rd_q <= fwd;
      if (rst_n && p2_v)
        for (int i = 0; i < LANES; i++)
          if (!p2_m[i]) mem[p2_a][i*LW +: LW] <= wdata[i*LW +: LW];
    end
  end

  assign rvalid = rv_q && !out_en_n && !slp2;
  assign rdata  = rvalid ? rd_q : '0;

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rv_q) && $stable(p1_v) && $stable(p2_v) && $stable(cnt) && $stable(act));

  p_sleep_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slp2 |=> $stable(rv_q) && $stable(p1_v) && $stable(p2_v) && $stable(cnt) && $stable(act));

  p_wpipe_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p2_v && $past(run) |-> $past(p1_v && p1_wr));

  p_rvalid_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rv_q) |-> $past(p1_v && !p1_wr));

  p_desel_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_n && !sel |=> !p1_v && !act);

  p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && act && load_n |=> cnt == $past(cnt) + 2'd1);
endmodule

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, stall = 1'b0, en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
  logic load_n = 1'b0, wr_n = 1'b1, burst_lin = 1'b1, out_en_n = 1'b0, sleep = 1'b0;
  logic [3:0] lane_wen_n = 4'h0;
  logic [5:0] addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic rvalid;

  pipe_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .load_n(load_n), .wr_n(wr_n), .lane_wen_n(lane_wen_n), .addr(addr), .wdata(wdata),
    .burst_lin(burst_lin), .out_en_n(out_en_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
  );

  localparam logic [35:0] D0 = 36'h1A2B3C4D5, D1 = 36'h2468ACE13, D2 = 36'h5A5A5A5A5;
  localparam logic [35:0] D3 = 36'hFEDCBA987, D4 = 36'h0F0F0F0F0, MRG = 36'h1A2B3C587;
  localparam logic [35:0] B0 = 36'h111111111, B1 = 36'h222222222, B2 = 36'h333333333;
  localparam logic [35:0] B3 = 36'h444444444, C0 = 36'h9ABCDEF01, JK = 36'hDEADBEEF7;

  typedef struct packed {
    logic ld_n; logic sel; logic w_n; logic [3:0] ln; logic [5:0] a;
    logic [35:0] wd; logic oen; logic ev; logic [35:0] ed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,4'h0,6'h06,36'h0,1'b0,1'b0,36'h0},   // R2 write 6
    '{1'b0,1'b1,1'b0,4'h0,6'h04,36'h0,1'b0,1'b0,36'h0},   // R2 write 4
    '{1'b0,1'b1,1'b0,4'h0,6'h05,D0,   1'b0,1'b0,36'h0},   // R2 write 5, data of 6
    '{1'b0,1'b1,1'b1,4'h0,6'h04,D1,   1'b0,1'b0,36'h0},   // R2 read 4 right after writes
    '{1'b0,1'b1,1'b0,4'hE,6'h06,D2,   1'b0,1'b1,D1},      // R1 R3 lane-0 write after read
    '{1'b0,1'b1,1'b1,4'h0,6'h06,36'h0,1'b0,1'b0,36'h0},   // R9 read of pending write
    '{1'b0,1'b1,1'b1,4'h0,6'h05,D3,   1'b0,1'b1,MRG},     // R9 R3 merged lane
    '{1'b0,1'b1,1'b0,4'hF,6'h04,36'h0,1'b0,1'b1,D2},      // R3 abort to 4
    '{1'b0,1'b1,1'b1,4'h0,6'h04,36'h0,1'b0,1'b0,36'h0},   // R3 read 4
    '{1'b0,1'b0,1'b1,4'h0,6'h00,D4,   1'b0,1'b1,D1},      // R3 abort data dropped, R5 deselect
    '{1'b1,1'b0,1'b1,4'h0,6'h00,36'h0,1'b0,1'b0,36'h0},   // R5 continue deselect
    '{1'b0,1'b1,1'b1,4'h0,6'h05,36'h0,1'b0,1'b0,36'h0},   // R1 read 5
    '{1'b0,1'b0,1'b1,4'h0,6'h00,36'h0,1'b1,1'b0,36'h0},   // R7 hidden by out_en_n
    '{1'b0,1'b0,1'b1,4'h0,6'h00,36'h0,1'b0,1'b0,36'h0}    // R1 idle
  };

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic ev, input logic [35:0] ed);
    nchk++;
    if (rvalid !== ev || rdata !== (ev ? ed : 36'h0)) begin
      nfail++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ev ? ed : 36'h0);
    end
  endtask

  task automatic drive(input logic ld, input logic s, input logic w, input logic [3:0] ln,
                       input logic [5:0] a, input logic [35:0] wd, input logic st);
    load_n = ld; en1_n = !s; en2 = s; en3_n = !s; wr_n = w;
    lane_wen_n = ln; addr = a; wdata = wd; stall = st;
  endtask

  task automatic step(input logic ld, input logic s, input logic w, input logic [3:0] ln,
                      input logic [5:0] a, input logic [35:0] wd, input logic st);
    drive(ld, s, w, ln, a, wd, st);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic desel(input logic [35:0] wd);
    step(1'b0, 1'b0, 1'b1, 4'h0, 6'h0, wd, 1'b0);
  endtask

  task automatic cont();
    step(1'b1, 1'b1, 1'b1, 4'h0, 6'h0, 36'h0, 1'b0);
  endtask

  task automatic rd(input logic [5:0] a, input logic [35:0] exp, input string tag);
    step(1'b0, 1'b1, 1'b1, 4'h0, a, 36'h0, 1'b0);
    desel(36'h0);
    chk(tag, 1'b1, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    desel(36'h0);
    chk("R10 after reset", 1'b0, 36'h0);

    for (int i = 0; i < NV; i++) begin
      out_en_n = TBL[i].oen;
      step(TBL[i].ld_n, TBL[i].sel, TBL[i].w_n, TBL[i].ln, TBL[i].a, TBL[i].wd, 1'b0);
      chk($sformatf("vector %0d", i), TBL[i].ev, TBL[i].ed);
    end

    // R4 linear write burst starting at 0x0A: 0A,0B,08,09
    burst_lin = 1'b1;
    step(1'b0, 1'b1, 1'b0, 4'h0, 6'h0A, 36'h0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'h0, 6'h00, 36'h0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'h0, 6'h00, B0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'h0, 6'h00, B1, 1'b0);
    desel(B2);
    step(1'b1, 1'b0, 1'b1, 4'h0, 6'h00, B3, 1'b0);

    // R4 interleaved read from 0x09: 09,08,0B,0A
    burst_lin = 1'b0;
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h09, 36'h0, 1'b0);
    cont(); chk("R4 interleave beat0", 1'b1, B3);
    cont(); chk("R4 interleave beat1", 1'b1, B2);
    cont(); chk("R4 interleave beat2", 1'b1, B1);
    desel(36'h0); chk("R4 interleave beat3", 1'b1, B0);

    // R4 linear read from 0x0B with wrap: 0B,08,09,0A,0B
    burst_lin = 1'b1;
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h0B, 36'h0, 1'b0);
    cont(); chk("R4 linear beat0", 1'b1, B1);
    cont(); chk("R4 linear beat1", 1'b1, B2);
    cont(); chk("R4 linear beat2", 1'b1, B3);
    cont(); chk("R4 linear beat3", 1'b1, B0);
    desel(36'h0); chk("R4 linear wrap", 1'b1, B1);

    // R5 deselect ends a burst
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h08, 36'h0, 1'b0);
    desel(36'h0); chk("R5 last read before deselect", 1'b1, B2);
    cont(); chk("R5 continue after deselect", 1'b0, 36'h0);
    cont(); chk("R5 continue after deselect", 1'b0, 36'h0);

    // R7 dummy reads advance the burst, output enable acts between edges
    out_en_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h08, 36'h0, 1'b0);
    cont(); chk("R7 hidden beat0", 1'b0, 36'h0);
    cont(); chk("R7 hidden beat1", 1'b0, 36'h0);
    out_en_n = 1'b0;
    desel(36'h0); chk("R7 third beat shown", 1'b1, B0);
    out_en_n = 1'b1; #0.5;
    chk("R7 async disable", 1'b0, 36'h0);
    out_en_n = 1'b0; #0.5;
    chk("R7 async enable", 1'b1, B0);

    // R6 stall freezes the read pipeline and ignores inputs
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h0A, 36'h0, 1'b0);
    chk("R6 before stall", 1'b0, 36'h0);
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h08, 36'h0, 1'b1);
    chk("R6 stalled", 1'b0, 36'h0);
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h08, 36'h0, 1'b1);
    chk("R6 stalled", 1'b0, 36'h0);
    desel(36'h0); chk("R6 read resumes", 1'b1, B0);
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h09, 36'h0, 1'b1);
    chk("R6 output held", 1'b1, B0);
    desel(36'h0); chk("R6 stalled command dropped", 1'b0, 36'h0);

    // R6 R2 stalled edge does not count toward write data delay
    step(1'b0, 1'b1, 1'b0, 4'h0, 6'h0C, 36'h0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 4'h0, 6'h00, JK, 1'b1);
    desel(JK);
    desel(C0);
    rd(6'h0C, C0, "R6 write delayed by stall");

    // R8 sleep
    sleep = 1'b1;
    desel(36'h0);
    desel(36'h0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 1'b0, 4'h0, 6'h0A, JK, 1'b0);
      chk("R8 asleep output idle", 1'b0, 36'h0);
    end
    sleep = 1'b0;
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h0B, JK, 1'b0);
    chk("R8 wake edge one ignored", 1'b0, 36'h0);
    desel(JK);
    chk("R8 wake edge two ignored", 1'b0, 36'h0);
    desel(JK);
    chk("R8 nothing pending after wake", 1'b0, 36'h0);
    rd(6'h0A, B0, "R8 contents kept");

    // R10 reset drops a pending write and a pending read
    step(1'b0, 1'b1, 1'b0, 4'h0, 6'h08, 36'h0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 4'h0, 6'h09, 36'h0, 1'b0);
    rst_n = 1'b0;
    desel(JK);
    desel(JK);
    chk("R10 in reset", 1'b0, 36'h0);
    rst_n = 1'b1;
    desel(JK);
    chk("R10 no read after reset", 1'b0, 36'h0);
    rd(6'h08, B2, "R10 no write after reset");
    rd(6'h09, B3, "R10 memory not cleared");

    finish_run();
  end
endmodule